// File: doc/BRIEF.md
# Boot Progress Code Trace Ring

This block records the byte codes that firmware writes to the I/O port 80h during boot. It keeps them in a ring of recent entries. The bus snooping logic in front of it reduces each qualifying bus cycle to three things: a strobe, the 4-bit bus command and the data byte. The block stores a byte only when the command is an I/O write. Each new byte goes into the next ring slot, so the oldest byte is lost once the ring is full.

A person browsing the history presses two buttons, step-forward and step-back. Their debounced single-cycle pulses move a read pointer that is independent of the write side. The block presents the byte under that pointer, together with four flags for a display driver:

- the pointer is on the newest entry;
- the pointer is on the oldest valid entry;
- the last move was a forward step;
- the last move was a backward step.

Each fresh capture returns the view to the newest entry. A fill count keeps the pointer from wandering into slots that have never been written since reset.

Top module: `post_trace_ring`

## Requirements
- R1: The ring holds DEPTH (default 32) entries of DATA_W (default 8) bits each, indexed 0 to DEPTH-1. The slot after index DEPTH-1 is index 0, and the slot before index 0 is index DEPTH-1.
- R2: Only the DEPTH most recently captured codes are retained. A capture into a full ring replaces the oldest entry.
- R3: `view_code` shows the entry under the read pointer, one clock after the edge that moved the pointer or wrote the entry. It shows 00h while the ring is empty.
- R4: A code is captured only when `cap_stb` is 1 and `cap_cmd` equals 4'b0011 (I/O write). A strobe with any other command value changes nothing.
- R5: After a capture, the read pointer sits on the new entry: `at_newest` is 1, and both `stepped_fwd` and `stepped_bwd` are 0.
- R6: A `btn_fwd` pulse alone moves the read pointer one entry toward the newest, sets `stepped_fwd` and clears `stepped_bwd`. On the newest entry, the pulse changes nothing.
- R7: A `btn_bwd` pulse alone moves the read pointer one entry toward the oldest, sets `stepped_bwd` and clears `stepped_fwd`. On the oldest valid entry, the pulse changes nothing.
- R8: `at_newest` and `at_oldest` are both 0 while the ring is empty. Both are 1 when exactly one entry is held.
- R9: When a capture and a button pulse arrive in the same cycle, only the capture takes effect.
- R10: When `btn_fwd` and `btn_bwd` pulse in the same cycle without a capture, they change nothing.
- R11: A synchronous active-high `rst` empties the ring, clears both pointers and both step flags, and drives `view_code` to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_stb | input | 1 | Snooped port-80h bus cycle strobe |
| cap_cmd | input | 4 | Bus command of that cycle |
| cap_data | input | DATA_W | Byte written by the host |
| btn_fwd | input | 1 | Debounced step-forward pulse |
| btn_bwd | input | 1 | Debounced step-back pulse |
| view_code | output | DATA_W | Entry under the read pointer |
| at_newest | output | 1 | Read pointer is on the newest entry |
| at_oldest | output | 1 | Read pointer is on the oldest valid entry |
| stepped_fwd | output | 1 | Last move was a forward step |
| stepped_bwd | output | 1 | Last move was a backward step |

## Verification
The bench builds the block with its default parameters: a 32-entry ring of 8-bit codes. With that depth, about seventy captures are enough to fill the ring twice and carry both pointers across the wrap from index 31 to index 0. A full backward walk then reaches the oldest surviving code. A short fill of five entries exercises the stops at both ends, and a single entry exercises the case where newest and oldest are the same slot. A long pseudo-random phase mixes in the following, each on its own clock cycle and in combination:
- foreign bus commands;
- simultaneous capture and button pulses;
- simultaneous forward and backward pulses.

// File: rtl/post_trace_pkg.sv
package post_trace_pkg;

  localparam logic [3:0] CMD_IO_WRITE = 4'b0011;

  // one slot up the ring
  function automatic int ring_next(input int idx, input int depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  // one slot down the ring
  function automatic int ring_prev(input int idx, input int depth);
    return (idx == 0) ? depth - 1 : idx - 1;
  endfunction

  // n slots down the ring, n in 0..depth
  function automatic int ring_back(input int idx, input int n, input int depth);
    return ((idx - n) % depth + depth) % depth;
  endfunction

endpackage

// File: rtl/io_write_filter.sv
module io_write_filter
  import post_trace_pkg::*;
(
  input  logic       stb,
  input  logic [3:0] cmd,
  output logic       accept
);
  assign accept = stb && (cmd == CMD_IO_WRITE);
endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/trace_ptrs.sv
module trace_ptrs
  import post_trace_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_acc,
  input  logic          fwd,
  input  logic          bwd,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] fill,
  output logic          is_newest,
  output logic          is_oldest,
  output logic          sf,
  output logic          sb
);
  logic [AW-1:0] newest_idx, oldest_idx;
  logic          nonempty, fwd_go, bwd_go;

  assign nonempty   = (fill != '0);
  assign newest_idx = AW'(ring_back(int'(wr_ptr), 1, DEPTH));
  assign oldest_idx = AW'(ring_back(int'(wr_ptr), int'(fill), DEPTH));
  assign is_newest  = nonempty && (rd_ptr == newest_idx);
  assign is_oldest  = nonempty && (rd_ptr == oldest_idx);

  // a step needs a lone button, no capture, and room to move
  assign fwd_go = !wr_acc && fwd && !bwd && nonempty && !is_newest;
  assign bwd_go = !wr_acc && bwd && !fwd && nonempty && !is_oldest;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      sf     <= 1'b0;
      sb     <= 1'b0;
    end else if (wr_acc) begin
      rd_ptr <= wr_ptr;
      wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
      if (fill != CW'(DEPTH)) fill <= fill + 1'b1;
      sf     <= 1'b0;
      sb     <= 1'b0;
    end else if (fwd_go) begin
      rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
      sf     <= 1'b1;
      sb     <= 1'b0;
    end else if (bwd_go) begin
      rd_ptr <= AW'(ring_prev(int'(rd_ptr), DEPTH));
      sf     <= 1'b0;
      sb     <= 1'b1;
    end
  end
endmodule

// File: rtl/post_trace_ring.sv
module post_trace_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_stb,
  input  logic [3:0]        cap_cmd,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              btn_fwd,
  input  logic              btn_bwd,
  output logic [DATA_W-1:0] view_code,
  output logic              at_newest,
  output logic              at_oldest,
  output logic              stepped_fwd,
  output logic              stepped_bwd
);
  logic              wr_acc;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     fill;
  logic [DATA_W-1:0] rd_word;

  io_write_filter u_filt (
    .stb(cap_stb), .cmd(cap_cmd), .accept(wr_acc)
  );

  trace_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .wr_acc(wr_acc), .fwd(btn_fwd), .bwd(btn_bwd),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .fill(fill),
    .is_newest(at_newest), .is_oldest(at_oldest),
    .sf(stepped_fwd), .sb(stepped_bwd)
  );

  trace_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_acc), .waddr(wr_ptr), .wdata(cap_data),
    .raddr(rd_ptr), .rdata(rd_word)
  );

  assign view_code = (fill == '0) ? '0 : rd_word;
endmodule

// File: rtl/post_trace_ring_chk.sv
module post_trace_ring_chk
  import post_trace_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cap_stb,
  input logic [3:0]        cap_cmd,
  input logic              btn_fwd,
  input logic              btn_bwd,
  input logic              wr_acc,
  input logic [CW-1:0]     fill,
  input logic [DATA_W-1:0] view_code,
  input logic              at_newest,
  input logic              at_oldest,
  input logic              stepped_fwd,
  input logic              stepped_bwd
);
  a_r2_fill_bounded: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  a_r4_foreign_ignored: assert property (@(posedge clk) disable iff (rst)
    (cap_stb && cap_cmd != CMD_IO_WRITE && !btn_fwd && !btn_bwd) |=>
    ($stable(view_code) && $stable(at_newest) && $stable(at_oldest)
     && $stable(stepped_fwd) && $stable(stepped_bwd)));

  a_r5_snap_newest: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> (at_newest && !stepped_fwd && !stepped_bwd));

  a_r6_fwd_stops: assert property (@(posedge clk) disable iff (rst)
    (at_newest && btn_fwd && !btn_bwd && !cap_stb) |=>
    (at_newest && $stable(view_code) && $stable(stepped_fwd) && $stable(stepped_bwd)));

  a_r7_bwd_stops: assert property (@(posedge clk) disable iff (rst)
    (at_oldest && btn_bwd && !btn_fwd && !cap_stb) |=>
    (at_oldest && $stable(view_code) && $stable(stepped_fwd) && $stable(stepped_bwd)));

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(stepped_fwd && stepped_bwd));

  a_r8_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    (fill == '0) |-> (!at_newest && !at_oldest && view_code == '0));

  a_r10_both_buttons: assert property (@(posedge clk) disable iff (rst)
    (btn_fwd && btn_bwd && !cap_stb) |=> ($stable(view_code) && $stable(at_newest)
     && $stable(stepped_fwd) && $stable(stepped_bwd)));
endmodule

bind post_trace_ring post_trace_ring_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cap_stb(cap_stb), .cap_cmd(cap_cmd),
  .btn_fwd(btn_fwd), .btn_bwd(btn_bwd), .wr_acc(wr_acc), .fill(fill),
  .view_code(view_code), .at_newest(at_newest), .at_oldest(at_oldest),
  .stepped_fwd(stepped_fwd), .stepped_bwd(stepped_bwd)
);

// File: tb/post_trace_ring_test.sv
`timescale 1ns/1ps
module post_trace_ring_test;
  localparam int DW = 8;
  localparam int DP = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_stb = 1'b0;
  logic [3:0] cap_cmd = 4'h0;
  logic [DW-1:0] cap_data = '0;
  logic btn_fwd = 1'b0, btn_bwd = 1'b0;
  logic [DW-1:0] view_code;
  logic at_newest, at_oldest, stepped_fwd, stepped_bwd;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference: queue oldest-first, read index into it
  logic [DW-1:0] q[$];
  int rp = 0;
  bit m_sf = 0, m_sb = 0;

  always #4 clk = ~clk;

  post_trace_ring #(.DATA_W(DW), .DEPTH(DP)) uut (
    .clk(clk), .rst(rst), .cap_stb(cap_stb), .cap_cmd(cap_cmd),
    .cap_data(cap_data), .btn_fwd(btn_fwd), .btn_bwd(btn_bwd),
    .view_code(view_code), .at_newest(at_newest), .at_oldest(at_oldest),
    .stepped_fwd(stepped_fwd), .stepped_bwd(stepped_bwd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int n = q.size();
    int ev = (n > 0) ? int'(q[rp]) : 0;
    bit en = (n > 0) && (rp == n - 1);
    bit eo = (n > 0) && (rp == 0);
    chk(int'(view_code) == ev, {tag, " R3 view_code"}, int'(view_code), ev);
    chk(at_newest == en, {tag, " R8 at_newest"}, int'(at_newest), int'(en));
    chk(at_oldest == eo, {tag, " R8 at_oldest"}, int'(at_oldest), int'(eo));
    chk(stepped_fwd == m_sf, {tag, " R6 stepped_fwd"}, int'(stepped_fwd), int'(m_sf));
    chk(stepped_bwd == m_sb, {tag, " R7 stepped_bwd"}, int'(stepped_bwd), int'(m_sb));
  endtask

  task automatic model_update();
    bit wr = cap_stb && (cap_cmd == 4'b0011);
    if (rst) begin
      q.delete(); rp = 0; m_sf = 0; m_sb = 0;
    end else if (wr) begin
      q.push_back(cap_data);
      if (q.size() > DP) void'(q.pop_front());
      rp = q.size() - 1; m_sf = 0; m_sb = 0;
    end else if (btn_fwd && !btn_bwd) begin
      if (q.size() > 0 && rp < q.size() - 1) begin rp++; m_sf = 1; m_sb = 0; end
    end else if (btn_bwd && !btn_fwd) begin
      if (q.size() > 0 && rp > 0) begin rp--; m_sb = 1; m_sf = 0; end
    end
  endtask

  // inputs set at the falling edge, applied at the next rising edge, checked at the falling edge after
  task automatic cyc(input bit s, input logic [3:0] c, input logic [DW-1:0] d,
                     input bit f, input bit b, input string tag);
    cap_stb = s; cap_cmd = c; cap_data = d; btn_fwd = f; btn_bwd = b;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic wr(input logic [DW-1:0] d, input string tag);
    cyc(1'b1, 4'b0011, d, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b0, "R11 in reset");
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b0, "R11 in reset");
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(view_code == 8'h00, "R11 reset view_code", int'(view_code), 0);
    chk(!at_newest && !at_oldest, "R8 empty flags", int'({at_newest, at_oldest}), 0);

    // R8: buttons on an empty ring
    cyc(1'b0, 4'h0, '0, 1'b1, 1'b0, "R6 fwd empty");
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b1, "R7 bwd empty");

    // R4: foreign commands ignored
    cyc(1'b1, 4'b0010, 8'hAA, 1'b0, 1'b0, "R4 io read");
    cyc(1'b1, 4'b0111, 8'hBB, 1'b0, 1'b0, "R4 mem write");
    chk(view_code == 8'h00, "R4 nothing stored", int'(view_code), 0);

    // one entry: newest and oldest coincide
    wr(8'hD0, "R5 first");
    chk(at_newest && at_oldest, "R8 single entry both", int'({at_newest, at_oldest}), 3);
    wr(8'hD1, "R5"); wr(8'hD3, "R5"); wr(8'hD4, "R5"); wr(8'hD5, "R5");

    for (int i = 0; i < 6; i++) cyc(1'b0, 4'h0, '0, 1'b0, 1'b1, "R7 walk back");
    chk(view_code == 8'hD0 && at_oldest, "R7 stop at oldest", int'(view_code), 'hD0);
    cyc(1'b1, 4'b1011, 8'h55, 1'b0, 1'b0, "R4 cfg write at oldest");
    for (int i = 0; i < 6; i++) cyc(1'b0, 4'h0, '0, 1'b1, 1'b0, "R6 walk fwd");
    chk(view_code == 8'hD5 && at_newest && stepped_fwd, "R6 stop at newest",
        int'(view_code), 'hD5);

    // R10 both buttons; R9 capture wins
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b1, "R7 one back");
    cyc(1'b0, 4'h0, '0, 1'b1, 1'b1, "R10 both");
    chk(view_code == 8'hD4 && stepped_bwd, "R10 no move", int'(view_code), 'hD4);
    cyc(1'b1, 4'b0011, 8'h07, 1'b0, 1'b1, "R9 write plus bwd");
    chk(view_code == 8'h07 && at_newest && !stepped_bwd, "R9 write wins",
        int'(view_code), 'h07);

    // R2 / R1: overfill to wrap the ring twice
    for (int i = 0; i < 70; i++) wr(DW'(i + 8'h10), "R2 fill");
    for (int i = 0; i < 35; i++) cyc(1'b0, 4'h0, '0, 1'b0, 1'b1, "R1 walk back");
    chk(view_code == DW'(70 - DP + 8'h10) && at_oldest, "R2 oldest survivor",
        int'(view_code), 70 - DP + 'h10);
    cyc(1'b0, 4'h0, '0, 1'b1, 1'b0, "R1 fwd from oldest");
    wr(8'h99, "R5 write while browsing");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 15));
      cyc(r < 3, (r == 1) ? 4'b0110 : 4'b0011, DW'($urandom), r inside {2, 5, 6, 9},
          r inside {2, 7, 8, 9, 10}, "R3 random");
    end

    // R11: mid-run reset
    do_reset();
    chk(view_code == 8'h00 && !stepped_fwd && !stepped_bwd, "R11 mid reset",
        int'(view_code), 0);
    wr(8'h3C, "R11 after reset");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule